// File: doc/BRIEF.md
# Package Sleep-State and Cache Way-Shrink Controller

This controller chooses the package low-power state from the sleep states that each core asks for. It also shrinks a set-associative second-level cache one way at a time while the package sits in its lowest state-retaining level, C4. Each core presents a request from C0 (running) to C4. The package follows the shallowest of these requests.

Each time the package goes from a shallower state into C4, the controller asks the cache to write back a small batch of ways. By default the batch is two ways out of eight, taken from the highest index downward. A way is cut from power only after the cache reports that its flush is complete.

When no way is left powered, the package moves to a deeper level, DC4. In DC4 the supply may drop further because the cache holds no state, and snoops go to memory. When any core wakes from DC4, the lowest-indexed ways are powered again, two by default. Snoops stay routed to memory until a fixed wake interval has passed. If a core wakes while a flush is in progress, the way being flushed is finished first and no further way is started.

Top module: `cstate_shrink_ctrl`

## Requirements
- R1: After reset the package state is C0 (code 0), and no flush request, power-gate, deep flag or memory snoop route is active.
- R2: Outside C4, DC4 and the wake interval, the package state equals the smallest core request. The codes are 0 to 4 for C0 to C4, and a request value of 5, 6 or 7 counts as C4. Core i drives bits [3i+2:3i] of the request bus.
- R3: The smallest request can reach 4 from a shallower level while ways are still powered. One cycle later the package reports 4 and a single flush request is raised, for the highest-indexed powered way. At most one flush request bit is ever set.
- R4: A flush-done bit for the way under flush gates that way in the next cycle. At the same time the request moves to the next lower powered way or drops. Flush-done bits for any other way are ignored.
- R5: At most SHRINK_STEP ways are flushed and gated per C4 entry. After that, no request is raised while the package stays at C4.
- R6: A core may go shallower than C4 during a flush. The flush of the current way still runs until its done bit arrives. In that same cycle the way is gated and the package state follows the requests, with no further flush.
- R7: In the cycle the last powered way is gated, the package state becomes 5 (DC4), and the deep flag and the memory snoop route assert.
- R8: In DC4, when the smallest request drops below 4, the controller ungates the MIN_EXIT_WAYS lowest-indexed ways and clears the deep flag. The package state becomes the request, capped at 3.
- R9: After leaving DC4, snoops stay routed to memory for WAKE_CYCLES cycles and then return to the cache. During that window C4 requests are held off, and the package reports 3.
- R10: A flush request never targets a gated way, and a way becomes gated only while its flush request and its done bit are both present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| core_req_i | input | 3*NUM_CORES | Requested sleep level per core, 3 bits each |
| flush_done_i | input | NUM_WAYS | Per-way flush completion from the cache |
| pkg_state_o | output | 3 | Resolved package state, 0..4 = C0..C4, 5 = DC4 |
| flush_req_o | output | NUM_WAYS | One-hot flush request per way |
| way_gate_o | output | NUM_WAYS | 1 = way is powered off |
| deep_o | output | 1 | Package is in DC4 |
| snoop_mem_o | output | 1 | 1 = snoops are served by memory, not the cache |

## Verification
Two events can fall in the same cycle. The completion of a way flush can coincide with a core waking to a shallower state. Separately, the final gated way can coincide with the per-entry step limit being reached. The bench provokes the first by raising one core's request above C4 and presenting the done bit in one cycle. It then expects the way gated, the flush dropped and the package state following the requests, all at once. It provokes the second by re-entering C4 with exactly the two wake ways powered. It then expects DC4 rather than a plain C4 hold after the second flush.

// File: rtl/cstate_shrink_pkg.sv
package cstate_shrink_pkg;

    typedef enum logic [2:0] {
        MODE_RUN    = 3'd0,
        MODE_SHRINK = 3'd1,
        MODE_HOLD   = 3'd2,
        MODE_DEEP   = 3'd3,
        MODE_WAKE   = 3'd4
    } mode_e;

    localparam int unsigned LVL_W = 3;

    localparam logic [LVL_W-1:0] LVL_C3  = 3'd3;
    localparam logic [LVL_W-1:0] LVL_C4  = 3'd4;
    localparam logic [LVL_W-1:0] LVL_DC4 = 3'd5;

endpackage

// File: rtl/cstate_min_resolve.sv
module cstate_min_resolve
    import cstate_shrink_pkg::*;
#(
    parameter int unsigned NUM_CORES = 2
) (
    input  logic [NUM_CORES*LVL_W-1:0] req_i,
    output logic [LVL_W-1:0]           min_o
);

    logic [LVL_W-1:0] clamped [NUM_CORES];

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_clamp
        logic [LVL_W-1:0] raw;
        assign raw        = req_i[c*LVL_W +: LVL_W];
        assign clamped[c] = (raw > LVL_C4) ? LVL_C4 : raw;
    end

    always_comb begin
        min_o = LVL_C4;
        for (int c = 0; c < NUM_CORES; c++) begin
            if (clamped[c] < min_o) begin
                min_o = clamped[c];
            end
        end
    end

endmodule

// File: rtl/cstate_way_pick.sv
module cstate_way_pick #(
    parameter int unsigned NUM_WAYS = 8,
    localparam int unsigned IDX_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic [NUM_WAYS-1:0] avail_i,
    output logic                found_o,
    output logic [IDX_W-1:0]    idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (avail_i[w]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(w);
            end
        end
    end

endmodule

// File: rtl/cstate_shrink_ctrl.sv
module cstate_shrink_ctrl
    import cstate_shrink_pkg::*;
#(
    parameter int unsigned NUM_CORES     = 2,
    parameter int unsigned NUM_WAYS      = 8,
    parameter int unsigned SHRINK_STEP   = 2,
    parameter int unsigned MIN_EXIT_WAYS = 2,
    parameter int unsigned WAKE_CYCLES   = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CORES*LVL_W-1:0]   core_req_i,
    input  logic [NUM_WAYS-1:0]          flush_done_i,
    output logic [LVL_W-1:0]             pkg_state_o,
    output logic [NUM_WAYS-1:0]          flush_req_o,
    output logic [NUM_WAYS-1:0]          way_gate_o,
    output logic                         deep_o,
    output logic                         snoop_mem_o
);

    localparam int unsigned IDX_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
    localparam int unsigned STEP_W = $clog2(SHRINK_STEP + 1);
    localparam int unsigned WAKE_W = (WAKE_CYCLES > 1) ? $clog2(WAKE_CYCLES) : 1;
    localparam logic [NUM_WAYS-1:0] EXIT_MASK = NUM_WAYS'((64'd1 << MIN_EXIT_WAYS) - 64'd1);
    localparam logic [STEP_W-1:0]   STEP_LAST = STEP_W'(SHRINK_STEP);
    localparam logic [WAKE_W-1:0]   WAKE_LAST = WAKE_W'(WAKE_CYCLES - 1);

    typedef struct packed {
        mode_e               mode;
        logic [LVL_W-1:0]    pkg;
        logic [IDX_W-1:0]    cur;
        logic [STEP_W-1:0]   step;
        logic [WAKE_W-1:0]   wcnt;
        logic [NUM_WAYS-1:0] flush;
        logic [NUM_WAYS-1:0] gate;
        logic                deep;
        logic                snoop;
    } ctrl_t;

    ctrl_t s_d, s_q;

    logic [LVL_W-1:0]    min_req;
    logic                shallow;
    logic [LVL_W-1:0]    capped;
    logic                cur_done;
    logic [NUM_WAYS-1:0] gate_after;
    logic                pick_found;
    logic [IDX_W-1:0]    pick_idx;
    logic [STEP_W-1:0]   step_inc;

    cstate_min_resolve #(.NUM_CORES(NUM_CORES)) u_resolve (
        .req_i (core_req_i),
        .min_o (min_req)
    );

    assign shallow    = (min_req < LVL_C4);
    assign capped     = shallow ? min_req : LVL_C3;
    assign cur_done   = (s_q.mode == MODE_SHRINK) && flush_done_i[s_q.cur];
    assign gate_after = s_q.gate | (cur_done ? (NUM_WAYS'(1) << s_q.cur) : '0);
    assign step_inc   = s_q.step + 1'b1;

    cstate_way_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
        .avail_i (~gate_after),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.mode)
            MODE_RUN: begin
                if (shallow) begin
                    s_d.pkg = min_req;
                end else if (pick_found) begin
                    s_d.mode  = MODE_SHRINK;
                    s_d.pkg   = LVL_C4;
                    s_d.cur   = pick_idx;
                    s_d.step  = '0;
                    s_d.flush = NUM_WAYS'(1) << pick_idx;
                end else begin
                    s_d.mode  = MODE_DEEP;
                    s_d.pkg   = LVL_DC4;
                    s_d.deep  = 1'b1;
                    s_d.snoop = 1'b1;
                end
            end
            MODE_SHRINK: begin
                if (cur_done) begin
                    s_d.gate  = gate_after;
                    s_d.flush = '0;
                    s_d.step  = step_inc;
                    if (shallow) begin
                        s_d.mode = MODE_RUN;
                        s_d.pkg  = min_req;
                    end else if (!pick_found) begin
                        s_d.mode  = MODE_DEEP;
                        s_d.pkg   = LVL_DC4;
                        s_d.deep  = 1'b1;
                        s_d.snoop = 1'b1;
                    end else if (step_inc == STEP_LAST) begin
                        s_d.mode = MODE_HOLD;
                    end else begin
                        s_d.cur   = pick_idx;
                        s_d.flush = NUM_WAYS'(1) << pick_idx;
                    end
                end
            end
            MODE_HOLD: begin
                if (shallow) begin
                    s_d.mode = MODE_RUN;
                    s_d.pkg  = min_req;
                end
            end
            MODE_DEEP: begin
                if (shallow) begin
                    s_d.mode = MODE_WAKE;
                    s_d.pkg  = min_req;
                    s_d.gate = s_q.gate & ~EXIT_MASK;
                    s_d.deep = 1'b0;
                    s_d.wcnt = '0;
                end
            end
            MODE_WAKE: begin
                s_d.pkg = capped;
                if (s_q.wcnt == WAKE_LAST) begin
                    s_d.mode  = MODE_RUN;
                    s_d.snoop = 1'b0;
                end else begin
                    s_d.wcnt = s_q.wcnt + 1'b1;
                end
            end
            default: begin
                s_d.mode = MODE_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode  <= MODE_RUN;
            s_q.pkg   <= '0;
            s_q.cur   <= '0;
            s_q.step  <= '0;
            s_q.wcnt  <= '0;
            s_q.flush <= '0;
            s_q.gate  <= '0;
            s_q.deep  <= 1'b0;
            s_q.snoop <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pkg_state_o = s_q.pkg;
    assign flush_req_o = s_q.flush;
    assign way_gate_o  = s_q.gate;
    assign deep_o      = s_q.deep;
    assign snoop_mem_o = s_q.snoop;

endmodule

// File: rtl/cstate_shrink_ctrl_chk.sv
module cstate_shrink_ctrl_chk
    import cstate_shrink_pkg::*;
#(
    parameter int unsigned NUM_CORES     = 2,
    parameter int unsigned NUM_WAYS      = 8,
    parameter int unsigned MIN_EXIT_WAYS = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NUM_CORES*LVL_W-1:0] core_req_i,
    input logic [NUM_WAYS-1:0]        flush_done_i,
    input logic [LVL_W-1:0]           pkg_state_o,
    input logic [NUM_WAYS-1:0]        flush_req_o,
    input logic [NUM_WAYS-1:0]        way_gate_o,
    input logic                       deep_o,
    input logic                       snoop_mem_o
);

    p_one_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_req_o));

    p_flush_powered_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o & way_gate_o) == '0);

    p_gate_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((way_gate_o & ~$past(way_gate_o)) != '0) |->
        ((way_gate_o & ~$past(way_gate_o)) == ($past(flush_req_o) & $past(flush_done_i))));

    p_flush_in_c4_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req_o != '0) |-> (pkg_state_o == LVL_C4));

    p_deep_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        deep_o |-> ((&way_gate_o) && snoop_mem_o && (pkg_state_o == LVL_DC4)));

    p_deep_from_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(deep_o) |-> ($past(flush_req_o) != '0));

    p_exit_ways_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(deep_o) |-> ($countones(~way_gate_o) >= MIN_EXIT_WAYS));

    p_pkg_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pkg_state_o <= LVL_DC4));

endmodule

bind cstate_shrink_ctrl cstate_shrink_ctrl_chk #(
    .NUM_CORES     (NUM_CORES),
    .NUM_WAYS      (NUM_WAYS),
    .MIN_EXIT_WAYS (MIN_EXIT_WAYS)
) u_chk (.*);

// File: tb/cstate_shrink_ctrl_test.sv
module cstate_shrink_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] core_req = '0;
    logic [7:0] done = '0;
    logic [2:0] pkg;
    logic [7:0] flush;
    logic [7:0] gate;
    logic       deep;
    logic       snoop;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef struct {
        logic [2:0] pkg;
        logic [7:0] flush;
        logic [7:0] gate;
        logic       deep;
        logic       snoop;
        string      tag;
    } exp_t;

    exp_t expq[$];

    always #5 clk = ~clk;

    cstate_shrink_ctrl uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .core_req_i   (core_req),
        .flush_done_i (done),
        .pkg_state_o  (pkg),
        .flush_req_o  (flush),
        .way_gate_o   (gate),
        .deep_o       (deep),
        .snoop_mem_o  (snoop)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input exp_t e);
        cmp(e.tag, "pkg",   int'(pkg),   int'(e.pkg));
        cmp(e.tag, "flush", int'(flush), int'(e.flush));
        cmp(e.tag, "gate",  int'(gate),  int'(e.gate));
        cmp(e.tag, "deep",  int'(deep),  int'(e.deep));
        cmp(e.tag, "snoop", int'(snoop), int'(e.snoop));
    endtask

    task automatic step(input logic [2:0] c0, input logic [2:0] c1, input logic [7:0] d,
                        input logic [2:0] ep, input logic [7:0] ef, input logic [7:0] eg,
                        input logic ed, input logic es, input string tag);
        exp_t e;
        @(negedge clk);
        core_req = {c1, c0};
        done     = d;
        e.pkg = ep; e.flush = ef; e.gate = eg; e.deep = ed; e.snoop = es; e.tag = tag;
        expq.push_back(e);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (expq.size() > 0) begin
                compare(expq.pop_front());
            end
        end
    end

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<=5000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : driver
        exp_t r;
        repeat (3) @(negedge clk);
        r.pkg = 0; r.flush = 0; r.gate = 0; r.deep = 0; r.snoop = 0; r.tag = "R1 reset";
        compare(r);
        rst_n = 1'b1;
        //    c0 c1 done  pkg flush gate  deep snoop
        step(1, 3, 8'h00, 1, 8'h00, 8'h00, 0, 0, "R2 min 1");
        step(3, 2, 8'h00, 2, 8'h00, 8'h00, 0, 0, "R2 min 2");
        step(4, 3, 8'h00, 3, 8'h00, 8'h00, 0, 0, "R2 one core C4");
        step(4, 4, 8'h00, 4, 8'h80, 8'h00, 0, 0, "R3 enter C4");
        step(4, 4, 8'h01, 4, 8'h80, 8'h00, 0, 0, "R4 stray done ignored");
        step(4, 4, 8'h80, 4, 8'h40, 8'h80, 0, 0, "R4 way7 gated");
        step(4, 4, 8'h40, 4, 8'h00, 8'hC0, 0, 0, "R5 step limit");
        step(4, 4, 8'h00, 4, 8'h00, 8'hC0, 0, 0, "R5 hold no flush");
        step(0, 4, 8'h00, 0, 8'h00, 8'hC0, 0, 0, "R2 back to C0");
        step(4, 4, 8'h00, 4, 8'h20, 8'hC0, 0, 0, "R3 second entry");
        step(4, 0, 8'h00, 4, 8'h20, 8'hC0, 0, 0, "R6 abort waits");
        step(4, 0, 8'h20, 0, 8'h00, 8'hE0, 0, 0, "R6 abort with done");
        step(4, 4, 8'h00, 4, 8'h10, 8'hE0, 0, 0, "R3 third entry");
        step(4, 4, 8'h10, 4, 8'h08, 8'hF0, 0, 0, "R4 way4");
        step(4, 4, 8'h08, 4, 8'h00, 8'hF8, 0, 0, "R5 way3 hold");
        step(2, 4, 8'h00, 2, 8'h00, 8'hF8, 0, 0, "R2 leave C4");
        step(4, 4, 8'h00, 4, 8'h04, 8'hF8, 0, 0, "R3 fourth entry");
        step(4, 4, 8'h04, 4, 8'h02, 8'hFC, 0, 0, "R4 way2");
        step(4, 4, 8'h02, 4, 8'h00, 8'hFE, 0, 0, "R5 way1 hold");
        step(1, 4, 8'h00, 1, 8'h00, 8'hFE, 0, 0, "R2 leave C4 again");
        step(4, 4, 8'h00, 4, 8'h01, 8'hFE, 0, 0, "R3 last way");
        step(4, 4, 8'h01, 5, 8'h00, 8'hFF, 1, 1, "R7 enter DC4");
        step(4, 4, 8'h00, 5, 8'h00, 8'hFF, 1, 1, "R7 stay DC4");
        step(4, 3, 8'h00, 3, 8'h00, 8'hFC, 0, 1, "R8 exit DC4");
        step(4, 3, 8'h00, 3, 8'h00, 8'hFC, 0, 1, "R9 wake 2");
        step(4, 3, 8'h00, 3, 8'h00, 8'hFC, 0, 1, "R9 wake 3");
        step(4, 3, 8'h00, 3, 8'h00, 8'hFC, 0, 0, "R9 snoop to cache");
        step(4, 4, 8'h00, 4, 8'h02, 8'hFC, 0, 0, "R3 entry after wake");
        step(4, 4, 8'h02, 4, 8'h01, 8'hFE, 0, 0, "R4 way1 again");
        step(4, 4, 8'h01, 5, 8'h00, 8'hFF, 1, 1, "R7 DC4 beats step limit");
        step(7, 4, 8'h00, 5, 8'h00, 8'hFF, 1, 1, "R2 code7 counts as C4");
        step(0, 6, 8'h00, 0, 8'h00, 8'hFC, 0, 1, "R8 exit to C0");
        step(4, 4, 8'h00, 3, 8'h00, 8'hFC, 0, 1, "R9 C4 deferred");
        step(4, 4, 8'h00, 3, 8'h00, 8'hFC, 0, 1, "R9 C4 deferred 2");
        step(4, 4, 8'h00, 3, 8'h00, 8'hFC, 0, 0, "R9 window over");
        step(4, 4, 8'h00, 4, 8'h02, 8'hFC, 0, 0, "R3 deferred entry");
        step(4, 4, 8'hFD, 4, 8'h02, 8'hFC, 0, 0, "R10 other done ignored");
        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule